// File: doc/BRIEF.md
# Windowed Analog Watchdog Checker

This block watches the stream of conversion results that a converter sequencer produces and flags any result that falls outside a programmable window bounded by a low and a high threshold. In single-channel operation (one-shot or plain continuous) every result is checked, and a violation raises a global watchdog flag on the next clock.

In multi-slot operation (channel scan or buffered single-channel runs), each slot index has its own enable bit and its own sticky status bit. Only enabled slots are checked. The global flag summarises the status bits. When the watchdog interrupt is disabled, the global flag is updated only at the end-of-sequence strobe. When it is enabled, the flag is raised immediately, and a stop request halts the sequencer.

Software clears the status bits and the flag through a simple write port. A zero bit clears and a one bit leaves the bit alone.

Top module: `awd_window_checker`

## Requirements
- R1: A result is out of window when it is strictly below `thr_lo` or strictly above `thr_hi`. A result equal to either threshold is inside the window.
- R2: With `mode_multi`=0, every valid out-of-window result sets `wd_flag` on the next clock, and `slot_stat` is never set.
- R3: With `mode_multi`=1, a valid out-of-window result whose slot index is below NUM_SLOTS and whose `slot_en` bit is 1 sets `slot_stat[slot]` on the next clock. Disabled slots and indices at or above NUM_SLOTS change nothing.
- R4: With `mode_multi`=1 and `irq_en`=0, `wd_flag` rises only on the clock after an `eos` strobe, and only if some status bit is set at that point (including one set in the `eos` cycle itself).
- R5: With `mode_multi`=1 and `irq_en`=1, a status-setting result also sets `wd_flag` on the same next clock, and `stop_req` is then high.
- R6: `irq` equals `wd_flag` AND `irq_en`. `stop_req` is high only while `wd_flag`, `irq_en` and `mode_multi` are all 1, so single-channel operation is never stopped.
- R7: Status bits and the flag are sticky. A write with `wr_sel`=1 clears each `slot_stat` bit whose `wr_data` bit is 0. A write with `wr_sel`=0 clears `wd_flag` when `wr_data[0]`=0. One bits have no effect. A hardware set in the same cycle wins over a clear.
- R8: Thresholds are taken in the cycle of each result, so a threshold change affects only results presented in that cycle or later.
- R9: After reset, `slot_stat`, `wd_flag`, `irq` and `stop_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | Conversion result strobe |
| res_slot | input | SLOT_W | Slot index of the result |
| res_data | input | DATA_W | Conversion result |
| thr_lo | input | DATA_W | Low threshold |
| thr_hi | input | DATA_W | High threshold |
| slot_en | input | NUM_SLOTS | Per-slot check enables (multi-slot mode) |
| mode_multi | input | 1 | 1 = scan/buffered, 0 = single/continuous |
| irq_en | input | 1 | Watchdog interrupt enable |
| eos | input | 1 | End-of-sequence strobe |
| wr_en | input | 1 | Clear-write strobe |
| wr_sel | input | 1 | 0 = global flag, 1 = status vector |
| wr_data | input | NUM_SLOTS | Write data; zero bits clear |
| slot_stat | output | NUM_SLOTS | Sticky per-slot status |
| wd_flag | output | 1 | Global watchdog flag |
| irq | output | 1 | Interrupt request |
| stop_req | output | 1 | Stop request to the sequencer |

## Verification
Single-channel results are applied exactly at each threshold, one step beyond each threshold, and well inside the window. This separates strict from inclusive comparison and confirms that the status vector stays idle. Multi-slot runs mix enabled slots, disabled slots and an out-of-range index, and are run with the interrupt both off and on. This shows the difference between flag timing deferred to end-of-sequence and immediate flag timing with a stop. Clear writes with mixed zero and one bits, a clear that collides with a hardware set, and a threshold change in the same cycle as a result test stickiness, set priority and per-result threshold sampling.

// File: rtl/awd_pkg.sv
package awd_pkg;
  typedef enum logic {
    SEL_FLAG = 1'b0,
    SEL_STAT = 1'b1
  } wr_sel_e;
endpackage

// File: rtl/awd_window_cmp.sv
module awd_window_cmp #(
  parameter int DATA_W = 10
) (
  input  logic [DATA_W-1:0] data,
  input  logic [DATA_W-1:0] lo,
  input  logic [DATA_W-1:0] hi,
  output logic              outside
);
  always_comb begin
    outside = (data < lo) || (data > hi);
  end
endmodule

// File: rtl/awd_slot_status.sv
module awd_slot_status #(
  parameter int NUM_SLOTS = 10,
  parameter int SLOT_W    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 chk_valid,
  input  logic [SLOT_W-1:0]    chk_slot,
  input  logic [NUM_SLOTS-1:0] chk_en,
  input  logic                 clr_en,
  input  logic [NUM_SLOTS-1:0] clr_keep,
  output logic [NUM_SLOTS-1:0] stat_q,
  output logic [NUM_SLOTS-1:0] stat_d,
  output logic                 hit_any
);
  logic [NUM_SLOTS-1:0] hit;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    always_comb begin
      hit[i]    = chk_valid && chk_en[i] && (chk_slot == SLOT_W'(i));
      stat_d[i] = (stat_q[i] && !(clr_en && !clr_keep[i])) || hit[i];
    end
  end

  always_comb begin
    hit_any = |hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end
endmodule

// File: rtl/awd_flag_ctrl.sv
module awd_flag_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic single_hit,
  input  logic slot_hit,
  input  logic mode_multi,
  input  logic irq_en,
  input  logic eos,
  input  logic stat_any_d,
  input  logic clr,
  output logic flag_q
);
  logic set_now;
  logic flag_d;

  always_comb begin
    set_now = (!mode_multi && single_hit)
           || (mode_multi && irq_en && slot_hit)
           || (mode_multi && !irq_en && eos && stat_any_d);
    flag_d  = (flag_q && !clr) || set_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end
endmodule

// File: rtl/awd_window_checker.sv
module awd_window_checker #(
  parameter int DATA_W    = 10,
  parameter int NUM_SLOTS = 10,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 res_valid,
  input  logic [SLOT_W-1:0]    res_slot,
  input  logic [DATA_W-1:0]    res_data,
  input  logic [DATA_W-1:0]    thr_lo,
  input  logic [DATA_W-1:0]    thr_hi,
  input  logic [NUM_SLOTS-1:0] slot_en,
  input  logic                 mode_multi,
  input  logic                 irq_en,
  input  logic                 eos,
  input  logic                 wr_en,
  input  logic                 wr_sel,
  input  logic [NUM_SLOTS-1:0] wr_data,
  output logic [NUM_SLOTS-1:0] slot_stat,
  output logic                 wd_flag,
  output logic                 irq,
  output logic                 stop_req
);
  import awd_pkg::*;

  logic                 outside;
  logic                 viol;
  logic [NUM_SLOTS-1:0] stat_d;
  logic                 slot_hit;
  logic                 stat_clr;
  logic                 flag_clr;

  awd_window_cmp #(.DATA_W(DATA_W)) u_cmp (
    .data    (res_data),
    .lo      (thr_lo),
    .hi      (thr_hi),
    .outside (outside)
  );

  always_comb begin
    viol     = res_valid && outside;
    stat_clr = wr_en && (wr_sel == SEL_STAT);
    flag_clr = wr_en && (wr_sel == SEL_FLAG) && !wr_data[0];
  end

  awd_slot_status #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .chk_valid (viol && mode_multi),
    .chk_slot  (res_slot),
    .chk_en    (slot_en),
    .clr_en    (stat_clr),
    .clr_keep  (wr_data),
    .stat_q    (slot_stat),
    .stat_d    (stat_d),
    .hit_any   (slot_hit)
  );

  awd_flag_ctrl u_flag (
    .clk        (clk),
    .rst_n      (rst_n),
    .single_hit (viol),
    .slot_hit   (slot_hit),
    .mode_multi (mode_multi),
    .irq_en     (irq_en),
    .eos        (eos),
    .stat_any_d (|stat_d),
    .clr        (flag_clr),
    .flag_q     (wd_flag)
  );

  always_comb begin
    irq      = wd_flag && irq_en;
    stop_req = wd_flag && irq_en && mode_multi;
  end
endmodule

// File: rtl/awd_window_checker_sva.sv
module awd_window_checker_sva #(
  parameter int DATA_W    = 10,
  parameter int NUM_SLOTS = 10,
  parameter int SLOT_W    = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 res_valid,
  input logic [SLOT_W-1:0]    res_slot,
  input logic [DATA_W-1:0]    res_data,
  input logic [DATA_W-1:0]    thr_lo,
  input logic [DATA_W-1:0]    thr_hi,
  input logic [NUM_SLOTS-1:0] slot_en,
  input logic                 mode_multi,
  input logic                 irq_en,
  input logic                 eos,
  input logic                 wr_en,
  input logic [NUM_SLOTS-1:0] slot_stat,
  input logic                 wd_flag,
  input logic                 stop_req
);
  logic bad;
  logic en_hit;
  always_comb begin
    bad    = res_valid && ((res_data < thr_lo) || (res_data > thr_hi));
    en_hit = bad && mode_multi && ({1'b0, res_slot} < (SLOT_W+1)'(NUM_SLOTS))
             && slot_en[res_slot];
  end

  p_single_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bad && !mode_multi) |=> wd_flag);

  p_single_nostat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && mode_multi) |=> ((slot_stat & ~$past(slot_stat)) == '0));

  p_slot_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    en_hit |=> (slot_stat != '0));

  p_deferred_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_multi && !irq_en && !eos && !wd_flag) |=> !wd_flag);

  p_immediate_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_hit && irq_en) |=> (wd_flag && stop_req));

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (($past(slot_stat) & ~slot_stat) == '0) && !$fell(wd_flag));

  p_inside_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !bad && !mode_multi && !wd_flag) |=> !wd_flag);
endmodule

bind awd_window_checker awd_window_checker_sva #(
  .DATA_W(DATA_W), .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)
) u_sva (
  .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_slot(res_slot),
  .res_data(res_data), .thr_lo(thr_lo), .thr_hi(thr_hi), .slot_en(slot_en),
  .mode_multi(mode_multi), .irq_en(irq_en), .eos(eos), .wr_en(wr_en),
  .slot_stat(slot_stat), .wd_flag(wd_flag), .stop_req(stop_req)
);

// File: tb/awd_window_checker_bench.sv
module awd_window_checker_bench;
  localparam int DW = 10;
  localparam int NS = 10;
  localparam int SW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          res_valid;
  logic [SW-1:0] res_slot;
  logic [DW-1:0] res_data, thr_lo, thr_hi;
  logic [NS-1:0] slot_en, wr_data;
  logic          mode_multi, irq_en, eos, wr_en, wr_sel;
  logic [NS-1:0] slot_stat;
  logic          wd_flag, irq, stop_req;

  int compared = 0;
  int mismatched = 0;
  string cur_req = "R9";

  always #4 clk = ~clk;

  awd_window_checker #(.DATA_W(DW), .NUM_SLOTS(NS), .SLOT_W(SW)) u_awd_window_checker (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_slot(res_slot),
    .res_data(res_data), .thr_lo(thr_lo), .thr_hi(thr_hi), .slot_en(slot_en),
    .mode_multi(mode_multi), .irq_en(irq_en), .eos(eos), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .slot_stat(slot_stat),
    .wd_flag(wd_flag), .irq(irq), .stop_req(stop_req)
  );

  // behavioural reference model
  bit m_stat[NS];
  bit m_flag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_stat[i]) m_stat[i] = 0;
      m_flag = 0;
    end else begin
      int  d, lo, hi, s;
      bit  outw, shit, any;
      d = res_data; lo = thr_lo; hi = thr_hi; s = res_slot;
      outw = res_valid && (d < lo || d > hi);
      shit = 0;
      if (wr_en && wr_sel)
        for (int i = 0; i < NS; i++) if (!wr_data[i]) m_stat[i] = 0;
      if (mode_multi && outw && s < NS && slot_en[s]) begin
        m_stat[s] = 1;
        shit = 1;
      end
      any = 0;
      for (int i = 0; i < NS; i++) any |= m_stat[i];
      if (wr_en && !wr_sel && !wr_data[0]) m_flag = 0;
      if (!mode_multi && outw) m_flag = 1;
      if (mode_multi && irq_en && shit) m_flag = 1;
      if (mode_multi && !irq_en && eos && any) m_flag = 1;
    end
  end

  task automatic cmp1(string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      int ms;
      ms = 0;
      for (int i = 0; i < NS; i++) ms |= (int'(m_stat[i]) << i);
      cmp1("slot_stat", int'(slot_stat), ms);
      cmp1("wd_flag", int'(wd_flag), int'(m_flag));
      cmp1("irq", int'(irq), int'(m_flag && irq_en));
      cmp1("stop_req", int'(stop_req), int'(m_flag && irq_en && mode_multi));
    end
  end

  task automatic idle();
    res_valid = 0; eos = 0; wr_en = 0; wr_sel = 0; wr_data = '1;
  endtask

  task automatic step();
    @(negedge clk); #1; idle();
  endtask

  task automatic put(int slot, int data);
    res_valid = 1; res_slot = SW'(slot); res_data = DW'(data);
    step();
  endtask

  task automatic clr(bit sel, logic [NS-1:0] keep);
    wr_en = 1; wr_sel = sel; wr_data = keep;
    step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rst_n = 0; idle(); res_slot = '0; res_data = '0;
    thr_lo = 10'd100; thr_hi = 10'd900; slot_en = '0;
    mode_multi = 0; irq_en = 0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    @(negedge clk); #1;
    cur_req = "R9";
    cmp1("reset stat", int'(slot_stat), 0);
    cmp1("reset flag", int'({wd_flag, irq, stop_req}), 0);

    cur_req = "R1";  // equal thresholds and interior are inside
    put(0, 100); put(0, 900); put(0, 500); step();
    cur_req = "R2";
    put(0, 99); step();
    cur_req = "R7";
    clr(0, 10'h001); step();       // write one: no effect
    clr(0, 10'h000); step();       // clears flag
    cur_req = "R2";
    put(0, 901); step();
    clr(0, 10'h000);
    cur_req = "R6";                // single mode: irq without stop
    irq_en = 1; put(2, 0); step(); step();
    clr(0, 10'h000); irq_en = 0;

    cur_req = "R3";
    mode_multi = 1; slot_en = 10'b00_0000_1010;
    put(0, 50);                    // disabled slot
    put(12, 50);                   // out-of-range index
    put(3, 500);                   // inside
    put(1, 950); step();
    cur_req = "R4";
    put(3, 20); step(); step();
    eos = 1; step(); step();
    cur_req = "R7";
    clr(1, 10'b11_1111_1101); step();
    clr(1, 10'h000); clr(0, 10'h000); step();
    cur_req = "R4";                // status set in the eos cycle itself
    res_valid = 1; res_slot = 4'd1; res_data = 10'd1000; eos = 1; step(); step();
    clr(1, 10'h000); clr(0, 10'h000);
    eos = 1; step(); step();       // eos with nothing set

    cur_req = "R5";
    irq_en = 1; put(3, 5); step(); step();
    cur_req = "R7";                // hardware set beats a clear
    res_valid = 1; res_slot = 4'd1; res_data = 10'd999;
    wr_en = 1; wr_sel = 1; wr_data = '0; step(); step();
    clr(1, 10'h000); clr(0, 10'h000); step();

    cur_req = "R8";
    thr_hi = 10'd400; put(1, 500); step();
    thr_hi = 10'd900; put(3, 500); step();
    clr(1, 10'h000); clr(0, 10'h000);
    thr_lo = 10'd600; put(3, 500);
    thr_lo = 10'd100; step();
    mode_multi = 0; irq_en = 0; step();

    cur_req = "R9";
    rst_n = 0; step(); rst_n = 1; step();
    cmp1("post reset", int'({slot_stat, wd_flag, stop_req}), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule